// File: doc/BRIEF.md
# Clock-Enable Power-Down State Tracker

This block follows the low-power state of the device side of a DDR3-style memory. On every rising clock edge it registers the clock-enable level and the command pins (chip select, row strobe, column strobe, write enable). It compares that level with the one registered at the edge before. From that pair and the bank and burst status at the edge, it decides the action: stay awake, enter one of three kinds of power-down, stay in power-down, or exit. Bank and burst status arrive as plain status inputs from the rest of the device model. The block does not decode commands fully and has no model of the array.

Two checks run next to the state tracking. Any clock-enable transition must come with a deselect or no-operation command; any other command at such an edge raises a one-cycle illegal flag. A second check counts how many consecutive edges the clock-enable has held its level. A transition that comes before a parameterised minimum number of edges sets a violation flag that stays set until reset. All outputs are registered and reset is synchronous and active high.

Top module: `cke_pd_tracker`

## Requirements
- R1: During reset and in the cycle after it, the outputs are `state_o`=0 (idle), `action_o`=0 (none), `illegal_o`=0 and `cke_viol_o`=0. The clock-enable is assumed to have been high for at least the minimum hold count, so a low sample at the first edge after reset is an entry and not a violation.
- R2: At an edge where clock-enable is high at both the previous and the present edge, `action_o` becomes 0 (none). `state_o` becomes 1 (active) if any of `banks_open`, `rd_busy`, `wr_busy` or `pre_busy` is high, and 0 (idle) otherwise. Each output updates one cycle after the edge that sampled its inputs.
- R3: At an edge where clock-enable is low at both the previous and the present edge, `action_o` becomes 1 (stay in power-down) and `state_o` keeps its value, whatever the command pins show. `illegal_o` stays 0.
- R4: At a high-to-low edge with any of `rd_busy`, `wr_busy` or `pre_busy` high, `action_o` becomes 4 (power-down during a burst or precharge) and `state_o` becomes 2 (active power-down).
- R5: At a high-to-low edge with `banks_open` high and no busy input, `action_o` becomes 3 (active power-down entry) and `state_o` becomes 2.
- R6: At a high-to-low edge with all status inputs low, `action_o` becomes 5 (precharge power-down entry) and `state_o` becomes 3 (precharge power-down).
- R7: At a low-to-high edge, `action_o` becomes 2 (exit). `state_o` returns to the awake state recorded at the entry edge: 1 if any status input was high then, 0 otherwise.
- R8: At a clock-enable transition edge, a command other than deselect (`cs_n`=1) or no-operation (`cs_n`=0 with `ras_n`, `cas_n` and `we_n` all 1) sets `illegal_o` for exactly one cycle. The action of R4 to R7 is still taken. At non-transition edges `illegal_o` is 0.
- R9: A clock-enable transition at an edge where fewer than `MIN_EDGES` (default 3) consecutive edges have registered the current level sets `cke_viol_o`. The count includes the transition edge that started that level. Once set, `cke_viol_o` stays high until reset. A transition after exactly `MIN_EDGES` edges does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_open | input | 1 | One or more banks are open |
| rd_busy | input | 1 | Read burst in progress |
| wr_busy | input | 1 | Write burst in progress |
| pre_busy | input | 1 | Precharge in progress |
| state_o | output | 2 | 0 idle, 1 active, 2 active power-down, 3 precharge power-down |
| action_o | output | 3 | 0 none, 1 stay, 2 exit, 3 active entry, 4 busy entry, 5 precharge entry |
| illegal_o | output | 1 | Illegal command at a transition edge, one cycle |
| cke_viol_o | output | 1 | Sticky minimum-hold violation |

## Verification
Directed sequences enter power-down from each source condition: all idle, banks open, and read, write or precharge busy. Each is followed by an exit, which shows whether the entry flavour and the restored awake state are kept apart. Holding clock-enable low while the command pins carry active commands shows that the command is ignored during power-down. The same commands placed at entry and exit edges must raise the illegal flag. Transitions placed one edge short of the minimum hold and exactly at it separate the violation threshold from an off-by-one. A long random phase mixes status, command and level changes, and every cycle is compared against a behavioural reference model.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACTIVE  = 2'd1,
      ST_ACT_PD  = 2'd2,
      ST_PRE_PD  = 2'd3
   } dev_state_t;

   typedef enum logic [2:0] {
      PA_NONE      = 3'd0,
      PA_STAY_PD   = 3'd1,
      PA_EXIT_PD   = 3'd2,
      PA_ENTER_APD = 3'd3,
      PA_ENTER_BPD = 3'd4,
      PA_ENTER_PPD = 3'd5
   } pd_action_t;

   typedef struct packed {
      logic sel_n;
      logic row_n;
      logic col_n;
      logic wr_n;
   } cmd_pins_t;

   typedef struct packed {
      logic bank_open;
      logic rd;
      logic wr;
      logic pre;
   } dev_status_t;

endpackage

// File: rtl/cke_level_history.sv
module cke_level_history
   import cke_pd_pkg::*;
#(
   parameter int MIN_EDGES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic cke_i,
   output logic cke_prev_o,
   output logic toggle_o,
   output logic viol_o
);

   logic early;

   assign toggle_o = cke_i ^ cke_prev_o;

   always_ff @(posedge clk) begin
      if (rst) begin
         cke_prev_o <= 1'b1;
      end else begin
         cke_prev_o <= cke_i;
      end
   end

   generate
      if (MIN_EDGES <= 1) begin : g_no_hold
         assign early = 1'b0;
      end else begin : g_hold
         localparam int CW = $clog2(MIN_EDGES + 1);
         localparam logic [CW-1:0] LIMIT = CW'(MIN_EDGES);
         logic [CW-1:0] held;

         assign early = toggle_o && (held < LIMIT);

         always_ff @(posedge clk) begin
            if (rst) begin
               held <= LIMIT;
            end else if (toggle_o) begin
               held <= CW'(1);
            end else if (held < LIMIT) begin
               held <= held + CW'(1);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         viol_o <= 1'b0;
      end else if (early) begin
         viol_o <= 1'b1;
      end
   end

endmodule

// File: rtl/cke_cmd_classify.sv
module cke_cmd_classify
   import cke_pd_pkg::*;
(
   input  cmd_pins_t   cmd_i,
   input  dev_status_t stat_i,
   output logic        quiet_o,
   output pd_action_t  entry_o,
   output dev_state_t  awake_o
);

   logic any_busy;
   logic any_use;

   assign any_busy = stat_i.rd | stat_i.wr | stat_i.pre;
   assign any_use  = any_busy | stat_i.bank_open;

   always_comb begin
      quiet_o = cmd_i.sel_n | (cmd_i.row_n & cmd_i.col_n & cmd_i.wr_n);
   end

   always_comb begin
      if (any_busy) begin
         entry_o = PA_ENTER_BPD;
      end else if (stat_i.bank_open) begin
         entry_o = PA_ENTER_APD;
      end else begin
         entry_o = PA_ENTER_PPD;
      end
   end

   assign awake_o = any_use ? ST_ACTIVE : ST_IDLE;

endmodule

// File: rtl/cke_pd_fsm.sv
module cke_pd_fsm
   import cke_pd_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cke_prev_i,
   input  logic       cke_i,
   input  logic       quiet_i,
   input  pd_action_t entry_i,
   input  dev_state_t awake_i,
   output dev_state_t state_o,
   output pd_action_t action_o,
   output logic       illegal_o
);

   dev_state_t saved_q;
   dev_state_t state_d;
   dev_state_t saved_d;
   pd_action_t action_d;
   logic       illegal_d;

   always_comb begin
      state_d   = state_o;
      saved_d   = saved_q;
      action_d  = PA_NONE;
      illegal_d = 1'b0;
      unique case ({cke_prev_i, cke_i})
         2'b00: begin
            action_d = PA_STAY_PD;
         end
         2'b01: begin
            action_d  = PA_EXIT_PD;
            state_d   = saved_q;
            illegal_d = ~quiet_i;
         end
         2'b10: begin
            action_d  = entry_i;
            state_d   = (entry_i == PA_ENTER_PPD) ? ST_PRE_PD : ST_ACT_PD;
            saved_d   = awake_i;
            illegal_d = ~quiet_i;
         end
         default: begin
            action_d = PA_NONE;
            state_d  = awake_i;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_o   <= ST_IDLE;
         saved_q   <= ST_IDLE;
         action_o  <= PA_NONE;
         illegal_o <= 1'b0;
      end else begin
         state_o   <= state_d;
         saved_q   <= saved_d;
         action_o  <= action_d;
         illegal_o <= illegal_d;
      end
   end

endmodule

// File: rtl/cke_pd_tracker.sv
module cke_pd_tracker
   import cke_pd_pkg::*;
#(
   parameter int MIN_EDGES = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cke,
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       banks_open,
   input  logic       rd_busy,
   input  logic       wr_busy,
   input  logic       pre_busy,
   output logic [1:0] state_o,
   output logic [2:0] action_o,
   output logic       illegal_o,
   output logic       cke_viol_o
);

   generate
      if (MIN_EDGES < 1) begin : g_bad_min
         $error("cke_pd_tracker: MIN_EDGES must be at least 1");
      end
   endgenerate

   cmd_pins_t   cmd;
   dev_status_t stat;
   logic        cke_prev;
   logic        toggle;
   logic        quiet;
   pd_action_t  entry;
   dev_state_t  awake;
   dev_state_t  st;
   pd_action_t  act;

   assign cmd  = '{sel_n: cs_n, row_n: ras_n, col_n: cas_n, wr_n: we_n};
   assign stat = '{bank_open: banks_open, rd: rd_busy, wr: wr_busy, pre: pre_busy};

   cke_level_history #(.MIN_EDGES(MIN_EDGES)) u_hist (
      .clk        (clk),
      .rst        (rst),
      .cke_i      (cke),
      .cke_prev_o (cke_prev),
      .toggle_o   (toggle),
      .viol_o     (cke_viol_o)
   );

   cke_cmd_classify u_cls (
      .cmd_i   (cmd),
      .stat_i  (stat),
      .quiet_o (quiet),
      .entry_o (entry),
      .awake_o (awake)
   );

   cke_pd_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .cke_prev_i (cke_prev),
      .cke_i      (cke),
      .quiet_i    (quiet),
      .entry_i    (entry),
      .awake_i    (awake),
      .state_o    (st),
      .action_o   (act),
      .illegal_o  (illegal_o)
   );

   assign state_o  = st;
   assign action_o = act;

   logic unused_toggle;
   assign unused_toggle = toggle;

endmodule

// File: rtl/cke_pd_checker.sv
module cke_pd_checker #(
   parameter int MIN_EDGES = 3
) (
   input logic       clk,
   input logic       rst,
   input logic       cke,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic       banks_open,
   input logic       rd_busy,
   input logic       wr_busy,
   input logic       pre_busy,
   input logic [1:0] state_o,
   input logic [2:0] action_o,
   input logic       illegal_o,
   input logic       cke_viol_o
);

   logic       cke_q;
   int         run_len;
   logic       quiet;
   logic       idle_all;

   assign quiet    = cs_n | (ras_n & cas_n & we_n);
   assign idle_all = ~(banks_open | rd_busy | wr_busy | pre_busy);

   always_ff @(posedge clk) begin
      if (rst) begin
         cke_q   <= 1'b1;
         run_len <= MIN_EDGES;
      end else begin
         cke_q <= cke;
         if (cke != cke_q) begin
            run_len <= 1;
         end else if (run_len < MIN_EDGES) begin
            run_len <= run_len + 1;
         end
      end
   end

   p_awake_r2: assert property (@(posedge clk) disable iff (rst)
      (cke && cke_q) |=> (action_o == 3'd0 && state_o[1] == 1'b0));

   p_stay_r3: assert property (@(posedge clk) disable iff (rst)
      (!cke && !cke_q) |=> (action_o == 3'd1 && $stable(state_o) && !illegal_o));

   p_precharge_entry_r6: assert property (@(posedge clk) disable iff (rst)
      (cke_q && !cke && idle_all) |=> (state_o == 2'd3 && action_o == 3'd5));

   p_exit_r7: assert property (@(posedge clk) disable iff (rst)
      (!cke_q && cke) |=> (action_o == 3'd2 && state_o[1] == 1'b0));

   p_illegal_cmd_r8: assert property (@(posedge clk) disable iff (rst)
      ((cke != cke_q) && !quiet) |=> illegal_o);

   p_illegal_only_on_toggle_r8: assert property (@(posedge clk) disable iff (rst)
      (cke == cke_q) |=> !illegal_o);

   p_early_toggle_r9: assert property (@(posedge clk) disable iff (rst)
      ((cke != cke_q) && (run_len < MIN_EDGES)) |=> cke_viol_o);

   p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      cke_viol_o |=> cke_viol_o);

endmodule

bind cke_pd_tracker cke_pd_checker #(.MIN_EDGES(MIN_EDGES)) u_cke_pd_chk (
   .clk        (clk),
   .rst        (rst),
   .cke        (cke),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .banks_open (banks_open),
   .rd_busy    (rd_busy),
   .wr_busy    (wr_busy),
   .pre_busy   (pre_busy),
   .state_o    (state_o),
   .action_o   (action_o),
   .illegal_o  (illegal_o),
   .cke_viol_o (cke_viol_o)
);

// File: tb/test_cke_pd_tracker.sv
`timescale 1ns/1ps
module test_cke_pd_tracker;

   localparam int MIN_EDGES = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cke = 1'b1;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic       banks_open = 1'b0, rd_busy = 1'b0, wr_busy = 1'b0, pre_busy = 1'b0;
   logic [1:0] state_o;
   logic [2:0] action_o;
   logic       illegal_o;
   logic       cke_viol_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model state
   int    m_prev, m_run, m_saved;
   int    e_state, e_act, e_ill, e_viol;
   string e_tag;

   always #5 clk = ~clk;

   cke_pd_tracker #(.MIN_EDGES(MIN_EDGES)) i_cke_pd_tracker (
      .clk(clk), .rst(rst), .cke(cke),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .banks_open(banks_open), .rd_busy(rd_busy), .wr_busy(wr_busy), .pre_busy(pre_busy),
      .state_o(state_o), .action_o(action_o), .illegal_o(illegal_o), .cke_viol_o(cke_viol_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(e_tag, "state", state_o, e_state);
      check(e_tag, "action", action_o, e_act);
      check("R8", "illegal", illegal_o, e_ill);
      check("R9", "violation", cke_viol_o, e_viol);
   endtask

   task automatic model_edge();
      bit quiet, any_busy, any_use;
      quiet    = cs_n || (ras_n && cas_n && we_n);
      any_busy = rd_busy || wr_busy || pre_busy;
      any_use  = any_busy || banks_open;
      e_ill = 0;
      if (m_prev == 0 && cke == 0) begin
         e_act = 1; e_tag = "R3";
      end else if (m_prev == 0) begin
         e_act = 2; e_state = m_saved; e_ill = !quiet; e_tag = "R7";
      end else if (cke == 0) begin
         if (any_busy) begin e_act = 4; e_state = 2; e_tag = "R4"; end
         else if (banks_open) begin e_act = 3; e_state = 2; e_tag = "R5"; end
         else begin e_act = 5; e_state = 3; e_tag = "R6"; end
         m_saved = any_use ? 1 : 0;
         e_ill = !quiet;
      end else begin
         e_act = 0; e_state = any_use ? 1 : 0; e_tag = "R2";
      end
      if (int'(cke) != m_prev) begin
         if (m_run < MIN_EDGES) e_viol = 1;
         m_run = 1;
      end else if (m_run < MIN_EDGES) begin
         m_run++;
      end
      m_prev = cke;
   endtask

   task automatic set_cmd(input int c);
      // 0 deselect, 1 no-operation, 2 activate-like, 3 write-like
      case (c)
         0: begin cs_n = 1; ras_n = 0; cas_n = 0; we_n = 0; end
         1: begin cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1; end
         2: begin cs_n = 0; ras_n = 0; cas_n = 1; we_n = 1; end
         default: begin cs_n = 0; ras_n = 1; cas_n = 0; we_n = 0; end
      endcase
   endtask

   task automatic set_stat(input bit b, input bit r, input bit w, input bit p);
      banks_open = b; rd_busy = r; wr_busy = w; pre_busy = p;
   endtask

   // called at a falling edge: drive, advance model, wait, compare
   task automatic step(input bit k, input int c);
      cke = k;
      set_cmd(c);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cke = 1'b1;
      set_cmd(1);
      set_stat(0, 0, 0, 0);
      m_prev = 1; m_run = MIN_EDGES; m_saved = 0;
      e_state = 0; e_act = 0; e_ill = 0; e_viol = 0; e_tag = "R1";
      repeat (2) @(negedge clk);
      compare_all();
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();                                        // R1
      // R1: low at first edge after reset is an entry without violation
      step(0, 1); step(0, 0); step(0, 1); step(1, 1); step(1, 1); step(1, 1);

      // R2: awake idle and active
      set_stat(1, 0, 0, 0); step(1, 2); step(1, 3);
      set_stat(0, 0, 0, 0); step(1, 1);

      // R6 then R3 with active commands ignored, then R7 back to idle
      step(0, 0); step(0, 2); step(0, 3); step(0, 1); step(1, 1);
      step(1, 1); step(1, 1);

      // R5: banks open entry, exit restores active
      set_stat(1, 0, 0, 0); step(1, 1); step(0, 1);
      set_stat(0, 0, 0, 0); step(0, 1); step(0, 1); step(1, 0);
      step(1, 1); step(1, 1);

      // R4: read, write and precharge busy entries
      set_stat(0, 1, 0, 0); step(0, 1); set_stat(0, 0, 0, 0); step(0, 1); step(0, 1); step(1, 1);
      step(1, 1); step(1, 1);
      set_stat(1, 0, 1, 0); step(0, 0); set_stat(0, 0, 0, 0); step(0, 1); step(0, 1); step(1, 1);
      step(1, 1); step(1, 1);
      set_stat(0, 0, 0, 1); step(0, 1); set_stat(0, 0, 0, 0); step(0, 1); step(0, 1); step(1, 1);
      step(1, 1); step(1, 1);

      // R8: illegal commands at entry and exit edges
      step(0, 2); step(0, 1); step(0, 1); step(1, 3); step(1, 2); step(1, 1);

      // R9: exactly MIN_EDGES is allowed, one short sets sticky flag
      step(0, 1); step(0, 1); step(0, 1); step(1, 1);
      step(1, 1); step(0, 1); step(0, 1); step(0, 1); step(1, 1); step(1, 1);
      do_reset();                                        // R1 clears R9 flag

      // random mix against the model
      for (int i = 0; i < 4000; i++) begin
         bit k;
         k = cke;
         if ($urandom_range(0, 5) == 0) k = ~cke;
         set_stat($urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0,
                  $urandom_range(0, 5) == 0, $urandom_range(0, 6) == 0);
         step(k, ($urandom_range(0, 7) == 0) ? 2 + int'($urandom_range(0, 1))
                                             : int'($urandom_range(0, 1)));
         if ($urandom_range(0, 999) == 0) do_reset();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule